// File: doc/BRIEF.md
# Flash Read Access Sequencer

This block stands between a simple read port and a flash array. Each accepted read is held for a programmable number of extra cycles before the array word is registered and returned. This lets one array run across a range of clock frequencies. The usual settings are 0 extra cycles below 23 MHz, 1 up to 45 MHz, 2 up to 68 MHz and 3 up to 90 MHz.

The array can be busy with a program or erase operation when a read arrives. A three-bit collision policy then picks the response:
- Reject the read at once with an error.
- Hold the read until the array is free. While holding, the block may also pulse a stall notification, or ask the program/erase engine to abandon its work, with or without an abort notification pulse.

Both settings live in a small configuration register that software writes through a one-cycle write strobe. After reset the register holds a wait count of 2 and the plain-stall policy.

Top module: `flash_read_seq`

## Requirements
- R1: After reset all outputs are low. The configuration holds a wait count of 2 and policy 3'b111, so an idle-array read completes 3 cycles after acceptance, and a colliding read stalls without any notification or abort.
- R2: A read accepted (rdReq high while no read is in progress) with arrayBusy low raises rdReady for one cycle exactly waitCount+1 clock edges after the accepting edge. rdData then equals the array word at rdAddr, and rdError is low.
- R3: The wait count is 5 bits wide, and both extremes (0 and 31) give the R2 latency.
- R4: The wait count in force is the one held at the accepting edge. A configuration write during a read changes only later reads.
- R5: With policy bit 2 clear (3'b0xx), a read accepted while arrayBusy is high returns rdReady and rdError together on the accepting edge, with no wait states.
- R6: Policy 3'b111 stalls a colliding read without stallIrq, abortReq or abortIrq.
- R7: Policy 3'b110 stalls a colliding read and gives exactly one single-cycle stallIrq pulse, on the accepting edge.
- R8: Policies 3'b101 and 3'b100 raise abortReq on the accepting edge of a colliding read and hold it, with rdReady low, until arrayBusy is seen low. 3'b101 gives no abortIrq.
- R9: Policy 3'b100 also gives exactly one single-cycle abortIrq pulse, on the accepting edge, while abortReq is high.
- R10: A stalled read leaves the stall on the first edge that sees arrayBusy low. abortReq drops at that edge, and rdReady follows waitCount+1 edges later, with rdError low and correct data.
- R11: rdReq is ignored while a read is waiting or stalled. No second completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWait | input | WS_W | Wait count to write |
| cfgPolicy | input | 3 | Collision policy to write |
| rdReq | input | 1 | Read request, taken when no read is in progress |
| rdAddr | input | ADDR_W | Read address |
| rdReady | output | 1 | One-cycle completion strobe |
| rdError | output | 1 | Error response, valid with rdReady |
| rdData | output | DATA_W | Registered read data |
| arrAddr | output | ADDR_W | Address presented to the array |
| arrData | input | DATA_W | Array read word |
| arrayBusy | input | 1 | Array busy with program or erase |
| abortReq | output | 1 | Request to abandon program/erase |
| stallIrq | output | 1 | Stall notification pulse |
| abortIrq | output | 1 | Abort notification pulse |

## Verification
The hardest case to reach is a stalled read whose release timing is exact. This means arrayBusy must fall at a chosen edge while abortReq and the notification pulses are being counted, and the read must still run its full wait count afterwards. The stimulus holds arrayBusy high across the accepting edge and drops it after a scripted number of cycles. Each cycle is sampled from the accepting edge onward, so the pulse counts, the abortReq duration and the completion latency are all checked against the scripted drop. A second case writes the configuration and raises a stray request in the middle of a long read, to show that neither has any effect on that read.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_STALL} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // capture read address
    logic finish;  // capture array word
  } dpStrobe_t;

  localparam logic [2:0] POL_RESET = 3'b111;
  localparam int unsigned WS_RESET = 2;

  function automatic logic polStalls(input logic [2:0] p);
    return p[2];
  endfunction
  function automatic logic polStallNote(input logic [2:0] p);
    return p == 3'b110;
  endfunction
  function automatic logic polAborts(input logic [2:0] p);
    return p[2] & ~p[1];
  endfunction
  function automatic logic polAbortNote(input logic [2:0] p);
    return p == 3'b100;
  endfunction
endpackage

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WS_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [WS_W-1:0]   cfgWait,
  input  logic [2:0]        cfgPolicy,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrData,
  input  dpStrobe_t         strobe,
  output logic [WS_W-1:0]   cfgWaitQ,
  output logic [2:0]        cfgPolQ,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [WS_W-1:0] WAIT_INIT = WS_W'(WS_RESET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWaitQ <= WAIT_INIT;
      cfgPolQ  <= POL_RESET;
    end else if (cfgWe) begin
      cfgWaitQ <= cfgWait;
      cfgPolQ  <= cfgPolicy;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arrAddr <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.accept) arrAddr <= rdAddr;
      if (strobe.finish) rdData  <= arrData;
    end
  end
endmodule

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl
  import flash_seq_pkg::*;
#(
  parameter int WS_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdReq,
  input  logic            arrayBusy,
  input  logic [WS_W-1:0] cfgWaitQ,
  input  logic [2:0]      cfgPolQ,
  output dpStrobe_t       strobe,
  output logic            rdReady,
  output logic            rdError,
  output logic            abortReq,
  output logic            stallIrq,
  output logic            abortIrq
);
  seqState_t       state;
  logic [WS_W-1:0] cnt;
  logic [WS_W-1:0] waitLat;

  always_comb begin
    strobe.accept = (state == ST_IDLE) && rdReq;
    strobe.finish = (state == ST_WAIT) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      waitLat  <= '0;
      rdReady  <= 1'b0;
      rdError  <= 1'b0;
      abortReq <= 1'b0;
      stallIrq <= 1'b0;
      abortIrq <= 1'b0;
    end else begin
      rdReady  <= 1'b0;
      rdError  <= 1'b0;
      stallIrq <= 1'b0;
      abortIrq <= 1'b0;
      unique case (state)
        ST_IDLE: if (rdReq) begin
          waitLat <= cfgWaitQ;
          if (!arrayBusy) begin
            state <= ST_WAIT;
            cnt   <= cfgWaitQ;
          end else if (!polStalls(cfgPolQ)) begin
            rdReady <= 1'b1;
            rdError <= 1'b1;
          end else begin
            state    <= ST_STALL;
            stallIrq <= polStallNote(cfgPolQ);
            abortReq <= polAborts(cfgPolQ);
            abortIrq <= polAbortNote(cfgPolQ);
          end
        end
        ST_STALL: if (!arrayBusy) begin
          state    <= ST_WAIT;
          cnt      <= waitLat;
          abortReq <= 1'b0;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            rdReady <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt - WS_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WS_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [WS_W-1:0]   cfgWait,
  input  logic [2:0]        cfgPolicy,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdReady,
  output logic              rdError,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] arrAddr,
  input  logic [DATA_W-1:0] arrData,
  input  logic              arrayBusy,
  output logic              abortReq,
  output logic              stallIrq,
  output logic              abortIrq
);
  dpStrobe_t       strobe;
  logic [WS_W-1:0] cfgWaitQ;
  logic [2:0]      cfgPolQ;

  flash_seq_ctl #(.WS_W(WS_W)) u_ctl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .arrayBusy(arrayBusy),
    .cfgWaitQ(cfgWaitQ), .cfgPolQ(cfgPolQ), .strobe(strobe),
    .rdReady(rdReady), .rdError(rdError), .abortReq(abortReq),
    .stallIrq(stallIrq), .abortIrq(abortIrq)
  );

  flash_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWait(cfgWait),
    .cfgPolicy(cfgPolicy), .rdAddr(rdAddr), .arrData(arrData),
    .strobe(strobe), .cfgWaitQ(cfgWaitQ), .cfgPolQ(cfgPolQ),
    .arrAddr(arrAddr), .rdData(rdData)
  );
endmodule

// File: rtl/flash_read_seq_chk.sv
module flash_read_seq_chk (
  input logic clk,
  input logic rstN,
  input logic arrayBusy,
  input logic rdReady,
  input logic rdError,
  input logic abortReq,
  input logic stallIrq,
  input logic abortIrq
);
  AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    rdError |-> rdReady); // R5
  AST_NOTES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(stallIrq && abortIrq)); // R7
  AST_STALL_NOTE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    stallIrq |=> !stallIrq); // R7
  AST_ABORT_NOTE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    abortIrq |=> !abortIrq); // R9
  AST_ABORT_NOTE_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    abortIrq |-> abortReq); // R9
  AST_NO_READY_IN_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> !rdReady); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && !arrayBusy) |=> !abortReq); // R10
endmodule

bind flash_read_seq flash_read_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .arrayBusy(arrayBusy), .rdReady(rdReady),
  .rdError(rdError), .abortReq(abortReq), .stallIrq(stallIrq),
  .abortIrq(abortIrq)
);

// File: tb/sim_flash_read_seq.sv
module sim_flash_read_seq;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int WS_W   = 5;
  localparam int NVEC   = 11;
  // {ws[23:19], policy[18:16], busyLen[15:8], addr[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {5'd0,  3'b111, 8'd0, 8'h11},
    {5'd1,  3'b111, 8'd0, 8'h22},
    {5'd3,  3'b110, 8'd0, 8'h33},
    {5'd31, 3'b111, 8'd0, 8'h44},
    {5'd2,  3'b000, 8'd3, 8'h55},
    {5'd2,  3'b011, 8'd2, 8'h66},
    {5'd1,  3'b111, 8'd4, 8'h77},
    {5'd4,  3'b110, 8'd2, 8'h88},
    {5'd0,  3'b101, 8'd3, 8'h99},
    {5'd2,  3'b100, 8'd1, 8'hAA},
    {5'd5,  3'b100, 8'd5, 8'hBB}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [WS_W-1:0] cfgWait = '0;
  logic [2:0] cfgPolicy = '0;
  logic rdReq = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic rdReady, rdError, abortReq, stallIrq, abortIrq;
  logic [DATA_W-1:0] rdData, arrData;
  logic [ADDR_W-1:0] arrAddr;
  logic arrayBusy = 1'b0;

  int total = 0;
  int fails = 0;
  int curWs = 2;
  logic [2:0] curPol = 3'b111;

  always #10 clk = ~clk;
  assign arrData = {arrAddr, ~arrAddr};

  flash_read_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWait(cfgWait),
    .cfgPolicy(cfgPolicy), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdReady(rdReady), .rdError(rdError), .rdData(rdData),
    .arrAddr(arrAddr), .arrData(arrData), .arrayBusy(arrayBusy),
    .abortReq(abortReq), .stallIrq(stallIrq), .abortIrq(abortIrq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doRead(input bit doCfg, input int ws, input logic [2:0] pol,
                        input logic [7:0] addr, input int busyLen,
                        input bit midWrite, input int midWs, input bit midReq,
                        input string latTag);
    int n, lat, expLat, nStall, nAbIrq, nAbReq, expAbReq, extra;
    bit err, expErr, busy;
    logic [DATA_W-1:0] dat;
    string tag;
    if (doCfg) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgWait = WS_W'(ws); cfgPolicy = pol;
      curWs = ws; curPol = pol;
    end
    @(negedge clk);
    cfgWe = 1'b0;
    busy = (busyLen > 0);
    rdReq = 1'b1; rdAddr = addr; arrayBusy = busy;
    if (!busy) begin expLat = curWs + 1; expErr = 1'b0; end
    else if (!curPol[2]) begin expLat = 0; expErr = 1'b1; end
    else begin expLat = busyLen + curWs + 1; expErr = 1'b0; end
    expAbReq = (busy && curPol[2] && !curPol[1]) ? busyLen : 0;
    @(negedge clk);
    rdReq = 1'b0;
    n = 0; lat = -1; nStall = 0; nAbIrq = 0; nAbReq = 0; err = 1'b0; dat = '0;
    while (n < 300) begin
      nStall += int'(stallIrq);
      nAbIrq += int'(abortIrq);
      nAbReq += int'(abortReq);
      if (rdReady) begin lat = n; err = rdError; dat = rdData; break; end
      if (n + 1 == busyLen) arrayBusy = 1'b0;
      if (midWrite && n == 1) begin cfgWe = 1'b1; cfgWait = WS_W'(midWs); end
      if (midReq && n == 1) rdReq = 1'b1;
      if (n == 2) begin cfgWe = 1'b0; rdReq = 1'b0; end
      n++;
      @(negedge clk);
    end
    cfgWe = 1'b0; rdReq = 1'b0; arrayBusy = 1'b0;
    if (midWrite) curWs = midWs;
    if (latTag != "") tag = latTag;
    else if (!busy) tag = (expLat == 1 || expLat == 32) ? "R3" : "R2";
    else tag = expErr ? "R5" : "R10";
    chk(tag, "latency", lat, expLat);
    chk(expErr ? "R5" : "R2", "error flag", int'(err), int'(expErr));
    if (!expErr) chk(tag, "data", int'(dat), int'({addr, ~addr}));
    chk((busy && pol == 3'b110) ? "R7" : "R6", "stall pulses", nStall,
        (busy && curPol == 3'b110) ? 1 : 0);
    chk("R9", "abort pulses", nAbIrq, (busy && curPol == 3'b100) ? 1 : 0);
    chk("R8", "abort cycles", nAbReq, expAbReq);
    extra = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      extra += int'(rdReady);
    end
    chk(midReq ? "R11" : "R2", "extra completions", extra, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset",
        int'({rdReady, rdError, abortReq, stallIrq, abortIrq}), 0);
    // reset configuration: wait 2, plain stall
    doRead(1'b0, 0, 3'b000, 8'h5A, 0, 1'b0, 0, 1'b0, "R1");
    doRead(1'b0, 0, 3'b000, 8'hA5, 3, 1'b0, 0, 1'b0, "R1");
    for (int i = 0; i < NVEC; i++)
      doRead(1'b1, int'(VEC[i][23:19]), VEC[i][18:16], VEC[i][7:0],
             int'(VEC[i][15:8]), 1'b0, 0, 1'b0, "");
    // R4 and R11: config write and stray request during a long read
    doRead(1'b1, 6, 3'b111, 8'hC3, 0, 1'b1, 0, 1'b1, "R4");
    doRead(1'b0, 0, 3'b000, 8'h3C, 0, 1'b0, 0, 1'b0, "R4");
    // R11 during a stall
    doRead(1'b1, 1, 3'b101, 8'hE7, 4, 1'b0, 0, 1'b1, "R10");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule